// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash and turns single requests into the full command sequences needed to program or erase the part. A requester presents an operation code, a 24-bit start address and, for programming, a byte count. The sequencer pulls the data bytes one at a time from a first-word-fall-through source and drives a single-bit SPI master port (mode 0, most significant bit first). Every round starts with a write-enable command in a frame of its own, then sends the program or erase command. The block then reads the status register repeatedly until the device reports that it is idle. It does not wait out a fixed worst-case delay.

A program request may span several 256-byte pages. The sequencer cuts it into rounds. The first round runs from the start address to the end of its page, and every later round begins on a page boundary. Each round has its own write-enable, program frame and polling. Erase requests select one of four granularities, and the whole-device erase carries no address bytes. The number of status reads is bounded. When the bound runs out, the operation ends with a timeout code. Whether it succeeds, times out or is refused, every request ends with a one-cycle completion pulse that carries an error code.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle, and a request is taken only when `req_valid` and `req_ready` are both high. A `req_valid` raised while `req_ready` is low starts nothing and adds no SPI frame.
- R2: Each round opens with a frame holding only the byte 06h. Between any two frames of one operation, `spi_cs_n` stays high for at least `CS_GAP` clock cycles.
- R3: A program frame (`req_op` = 0) is the byte 02h, then three address bytes with the high byte first, then the data bytes. The data bytes are taken from `data_byte` in request order, one per cycle in which `data_pop` is high.
- R4: An erase frame sends 20h (`req_op` = 1, sector), 52h (`req_op` = 2, half block) or D8h (`req_op` = 3, block), followed by the three address bytes with the high byte first. For `req_op` = 4 (whole device) the frame is the single byte C7h.
- R5: No program frame crosses a `PAGE_BYTES` boundary. The first round ends at the end of its page, each later round starts at a page start, and the rounds together carry exactly `req_len_m1`+1 bytes.
- R6: After each program or erase frame, the block sends status frames of the form 05h, 00h and takes the second received byte as the status. It repeats these frames until bit 0 of that byte is 0. The other status bits are ignored.
- R7: If `POLL_MAX` status reads in a row all show bit 0 set, the operation ends with `err` = 1. No further frame is sent for that request, and any rounds still left are dropped.
- R8: `done` is a one-cycle pulse. On success it comes after the last round's final status read, with `err` = 0.
- R9: The SPI port works in mode 0. `spi_sck` is low whenever `spi_cs_n` is high, `spi_mosi` changes only while `spi_sck` is low, and each byte goes out most significant bit first.
- R10: A request with `req_op` of 5, 6 or 7 sends no frame and gets a `done` pulse with `err` = 2 in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | 0 program, 1 sector, 2 half block, 3 block, 4 whole-device erase |
| req_addr | input | 24 | Start address |
| req_len_m1 | input | LEN_W | Program byte count minus one |
| data_byte | input | 8 | Head of the data source |
| data_pop | output | 1 | Consume the head of the data source |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 2 | 0 ok, 1 status timeout, 2 unknown operation |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a page split combined with a status timeout in the middle of a multi-round program. The outcome depends on both the address offset and the device's busy behaviour. The bench includes a behavioural flash model whose busy time, counted in status reads, is set per request. It issues program requests that start a few bytes before a page end, span several pages, and hold the busy flag past `POLL_MAX`. These show that the rounds are cut at the right bytes and that a timeout stops the remaining rounds. A `req_valid` pulse in the middle of a long operation checks that busy requests are ignored.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [2:0] {
      OP_PROG   = 3'd0,
      OP_SECTOR = 3'd1,
      OP_HALF   = 3'd2,
      OP_BLOCK  = 3'd3,
      OP_CHIP   = 3'd4
   } flash_op_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_BADOP   = 2'd2
   } flash_err_e;

   localparam logic [7:0] CMD_WREN   = 8'h06;
   localparam logic [7:0] CMD_STATUS = 8'h05;

   function automatic logic [7:0] opcode_of(flash_op_e op);
      case (op)
         OP_PROG:   return 8'h02;
         OP_SECTOR: return 8'h20;
         OP_HALF:   return 8'h52;
         OP_BLOCK:  return 8'hD8;
         default:   return 8'hC7;
      endcase
   endfunction
endpackage

// File: rtl/fsq_spi_shifter.sv
module fsq_spi_shifter #(
   parameter int HALF_PERIOD = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       rx_last,
   output logic       done
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

   if (HALF_PERIOD < 1) begin : g_bad_half
      $error("HALF_PERIOD must be at least 1");
   end

   logic       busy_q, sck_q, mosi_q, rx_q, done_q;
   logic [6:0] sh_q;
   logic [2:0] bits_q;
   logic       tick;

   if (HALF_PERIOD == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cnt_q <= '0;
         else if (!busy_q || cnt_q == CW'(HALF_PERIOD-1)) cnt_q <= '0;
         else                                  cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(HALF_PERIOD-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         mosi_q <= 1'b0;
         rx_q   <= 1'b0;
         done_q <= 1'b0;
         sh_q   <= '0;
         bits_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            mosi_q <= tx[7];
            sh_q   <= tx[6:0];
            bits_q <= '0;
         end else if (busy_q && tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               rx_q  <= miso;
            end else begin
               sck_q <= 1'b0;
               if (bits_q == 3'd7) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bits_q <= bits_q + 1'b1;
                  mosi_q <= sh_q[6];
                  sh_q   <= {sh_q[5:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck     = sck_q;
   assign mosi    = mosi_q;
   assign rx_last = rx_q;
   assign done    = done_q;

   // R9: data line is held across every rising clock edge
   assert_mosi_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> $stable(mosi_q));
endmodule

// File: rtl/fsq_page_split.sv
module fsq_page_split #(
   parameter int PAGE_BYTES = 256,
   parameter int REM_W      = 11
) (
   input  logic [$clog2(PAGE_BYTES)-1:0]   offset,
   input  logic [REM_W-1:0]                remain,
   output logic [$clog2(PAGE_BYTES+1)-1:0] chunk
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CH_W = $clog2(PAGE_BYTES+1);

   logic [CH_W-1:0] space;
   logic [31:0]     r32, s32;

   always_comb begin
      space = CH_W'(PAGE_BYTES) - CH_W'(offset);
      r32   = 32'(remain);
      s32   = 32'(space);
      chunk = CH_W'((r32 < s32) ? r32 : s32);
   end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_seq_pkg::*;
#(
   parameter int HALF_PERIOD = 2,
   parameter int PAGE_BYTES  = 256,
   parameter int LEN_W       = 10,
   parameter int POLL_MAX    = 1000,
   parameter int CS_GAP      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_len_m1,
   input  logic [7:0]       data_byte,
   output logic             data_pop,
   output logic             done,
   output logic [1:0]       err,
   output logic             spi_cs_n,
   output logic             spi_sck,
   output logic             spi_mosi,
   input  logic             spi_miso
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int ADDR_W = 24;
   localparam int REM_W  = LEN_W + 1;
   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam int CH_W   = $clog2(PAGE_BYTES + 1);
   localparam int IDX_W  = $clog2(PAGE_BYTES + 5);
   localparam int POLL_W = $clog2(POLL_MAX + 1);
   localparam int GAP_W  = $clog2(CS_GAP + 1);

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (POLL_MAX < 1 || CS_GAP < 1 || LEN_W < 1) begin : g_bad_count
      $error("POLL_MAX, CS_GAP and LEN_W must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_SHIFT, S_GAP} state_e;
   typedef enum logic [1:0] {K_WREN, K_CMD, K_POLL} kind_e;

   state_e            state_q;
   kind_e             kind_q;
   flash_op_e         op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REM_W-1:0]  remain_q;
   logic [IDX_W-1:0]  idx_q, frame_len;
   logic [POLL_W-1:0] poll_q;
   logic [GAP_W-1:0]  gap_q;
   logic              cs_n_q, done_q;
   flash_err_e        err_q;

   logic [CH_W-1:0]   chunk;
   logic [7:0]        tx_byte;
   logic              sh_start, sh_done, sh_rx;
   logic              last_byte, cmd_end;

   fsq_page_split #(.PAGE_BYTES(PAGE_BYTES), .REM_W(REM_W)) i_split (
      .offset (addr_q[PAGE_W-1:0]),
      .remain (remain_q),
      .chunk  (chunk)
   );

   fsq_spi_shifter #(.HALF_PERIOD(HALF_PERIOD)) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx      (tx_byte),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .rx_last (sh_rx),
      .done    (sh_done)
   );

   always_comb begin
      case (kind_q)
         K_WREN:  frame_len = IDX_W'(1);
         K_POLL:  frame_len = IDX_W'(2);
         default: frame_len = (op_q == OP_CHIP) ? IDX_W'(1) :
                              (op_q == OP_PROG) ? IDX_W'(4) + IDX_W'(chunk) : IDX_W'(4);
      endcase
      case (kind_q)
         K_WREN:  tx_byte = CMD_WREN;
         K_POLL:  tx_byte = (idx_q == '0) ? CMD_STATUS : 8'h00;
         default: begin
            case (idx_q)
               IDX_W'(0): tx_byte = opcode_of(op_q);
               IDX_W'(1): tx_byte = addr_q[23:16];
               IDX_W'(2): tx_byte = addr_q[15:8];
               IDX_W'(3): tx_byte = addr_q[7:0];
               default:   tx_byte = data_byte;
            endcase
         end
      endcase
   end

   assign sh_start  = (state_q == S_LAUNCH);
   assign data_pop  = sh_start && kind_q == K_CMD && idx_q >= IDX_W'(4);
   assign last_byte = (idx_q == frame_len - 1'b1);
   assign cmd_end   = (state_q == S_SHIFT) && sh_done && last_byte && kind_q == K_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         kind_q   <= K_WREN;
         op_q     <= OP_PROG;
         addr_q   <= '0;
         remain_q <= '0;
         idx_q    <= '0;
         poll_q   <= '0;
         gap_q    <= '0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         err_q    <= ERR_NONE;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: if (req_valid) begin
               if (req_op > 3'(OP_CHIP)) begin
                  done_q <= 1'b1;
                  err_q  <= ERR_BADOP;
               end else begin
                  op_q     <= flash_op_e'(req_op);
                  addr_q   <= req_addr;
                  remain_q <= (req_op == 3'(OP_PROG)) ? REM_W'(req_len_m1) + 1'b1 : '0;
                  kind_q   <= K_WREN;
                  idx_q    <= '0;
                  state_q  <= S_LAUNCH;
               end
            end
            S_LAUNCH: begin
               cs_n_q  <= 1'b0;
               state_q <= S_SHIFT;
            end
            S_SHIFT: if (sh_done) begin
               if (!last_byte) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_LAUNCH;
               end else begin
                  cs_n_q  <= 1'b1;
                  idx_q   <= '0;
                  gap_q   <= '0;
                  state_q <= S_GAP;
                  case (kind_q)
                     K_WREN: kind_q <= K_CMD;
                     K_CMD: begin
                        kind_q <= K_POLL;
                        poll_q <= '0;
                        if (op_q == OP_PROG) begin
                           addr_q   <= addr_q + ADDR_W'(chunk);
                           remain_q <= remain_q - REM_W'(chunk);
                        end
                     end
                     default: begin
                        if (!sh_rx) begin
                           if (remain_q != '0) kind_q <= K_WREN;
                           else begin
                              state_q <= S_IDLE;
                              done_q  <= 1'b1;
                              err_q   <= ERR_NONE;
                           end
                        end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
                           state_q <= S_IDLE;
                           done_q  <= 1'b1;
                           err_q   <= ERR_TIMEOUT;
                        end else begin
                           poll_q <= poll_q + 1'b1;
                        end
                     end
                  endcase
               end
            end
            default: begin
               if (gap_q == GAP_W'(CS_GAP - 1)) state_q <= S_LAUNCH;
               else                            gap_q   <= gap_q + 1'b1;
            end
         endcase
      end
   end

   assign req_ready = (state_q == S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign spi_cs_n  = cs_n_q;

   // R9: serial clock parked low outside a frame
   assert_sck_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   // R1: no request is taken while a frame is open
   assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> !req_ready);
   // R8: completion lasts one cycle
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: status read counter never passes its bound
   assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q < POLL_W'(POLL_MAX));
   // R5: after a program frame the next round starts on a page start
   assert_round_on_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_end && op_q == OP_PROG) |=> (addr_q[PAGE_W-1:0] == '0 || remain_q == '0));
endmodule

// File: tb/test_flash_seq.sv
module test_flash_seq;
   timeunit 1ns;
   timeprecision 1ps;
   import flash_seq_pkg::*;

   localparam int HP = 2, PB = 256, LW = 10, PM = 6, GAP = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req_valid = 1'b0, req_ready, data_pop, done;
   logic [2:0]    req_op = '0;
   logic [23:0]   req_addr = '0;
   logic [LW-1:0] req_len_m1 = '0;
   logic [7:0]    data_byte;
   logic [1:0]    err;
   logic          spi_cs_n, spi_sck, spi_mosi;
   logic          spi_miso = 1'b0;

   logic [7:0] src [0:1023];
   int         pop_idx = 0;
   assign data_byte = src[pop_idx[9:0]];
   always @(posedge clk) if (rst_n && data_pop) pop_idx <= pop_idx + 1;

   flash_seq #(.HALF_PERIOD(HP), .PAGE_BYTES(PB), .LEN_W(LW), .POLL_MAX(PM), .CS_GAP(GAP))
   i_flash_seq (.*);

   int compared = 0, mismatched = 0;
   task automatic chk(bit ok, string req, string what, int act, int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // behavioural flash model and expectation queues
   logic [7:0] exp_bytes[$];
   int         exp_lens[$];
   logic [7:0] fb[$];
   logic [7:0] shreg = '0, st = '0;
   int bitcnt = 0, busy_left = 0, cfg_busy = 0, gap_cnt = 100;
   int exp_err = 0, exp_pops = 0;
   bit model_active = 0, done_seen = 0;

   always @(posedge spi_sck) if (rst_n && !spi_cs_n) begin
      shreg = {shreg[6:0], spi_mosi};
      bitcnt++;
      if (bitcnt % 8 == 0) fb.push_back(shreg);
   end
   always @(negedge spi_sck) if (rst_n && !spi_cs_n) begin
      if (bitcnt >= 8 && bitcnt < 16) spi_miso = st[15 - bitcnt];
      else                            spi_miso = 1'b0;
   end
   always @(negedge spi_cs_n) if (rst_n) begin
      bitcnt = 0;
      st = (busy_left > 0) ? 8'h7F : 8'h7E;
      if (model_active) chk(gap_cnt >= GAP, "R2", "chip select high time", gap_cnt, GAP);
   end
   always @(posedge spi_cs_n) if (rst_n) begin
      check_frame();
      if (fb.size() > 0) begin
         if (fb[0] == 8'h05) begin
            if (busy_left > 0) busy_left--;
         end else if (fb[0] != 8'h06) busy_left = cfg_busy;
      end
      fb.delete();
      gap_cnt = 0;
   end

   task automatic check_frame();
      if (exp_lens.size() == 0) begin
         chk(0, "R1 R7", "unexpected frame length", fb.size(), 0);
      end else begin
         int L = exp_lens.pop_front();
         logic [7:0] first = exp_bytes[0];
         bit ok = (fb.size() == L);
         int act = fb.size(), expv = L;
         string tag;
         for (int i = 0; i < L; i++) begin
            logic [7:0] e = exp_bytes.pop_front();
            if (ok && fb[i] != e) begin ok = 0; act = fb[i]; expv = e; end
         end
         tag = (first == 8'h06) ? "R2" : (first == 8'h05) ? "R6" :
               (first == 8'h02) ? "R3 R5" : "R4";
         chk(ok, tag, "frame content", act, expv);
      end
   endtask

   always @(posedge clk)
      if (rst_n && req_valid && !model_active && req_op <= 3'd4) model_active = 1;

   logic prev_sck = 0, prev_mosi = 0;
   always @(negedge clk) if (rst_n) begin
      if (spi_cs_n) gap_cnt++;
      if (done) begin
         chk(err == exp_err[1:0], "R8 R7 R10", "completion code", err, exp_err);
         chk(exp_lens.size() == 0, "R6 R8", "frames still expected", exp_lens.size(), 0);
         chk(pop_idx == exp_pops, "R3", "bytes consumed", pop_idx, exp_pops);
         model_active = 0;
         done_seen = 1;
      end
      chk(req_ready == !model_active, "R1", "ready", req_ready, !model_active);
      chk(!(spi_cs_n && spi_sck), "R9", "clock while deselected", spi_sck, 0);
      chk(!(!spi_cs_n && prev_sck && spi_sck && spi_mosi != prev_mosi), "R9",
          "data moved while clock high", spi_mosi, prev_mosi);
      prev_sck = spi_sck;
      prev_mosi = spi_mosi;
   end

   function automatic void push_polls(int busy);
      int n = (busy >= PM) ? PM : busy + 1;
      for (int k = 0; k < n; k++) begin
         exp_bytes.push_back(8'h05); exp_bytes.push_back(8'h00); exp_lens.push_back(2);
      end
   endfunction

   function automatic void build(int op, int addr, int len, int busy);
      exp_pops = 0;
      if (op > 4) begin exp_err = 2; return; end
      exp_err = (busy >= PM) ? 1 : 0;
      if (op == 0) begin
         int a = addr, rem = len;
         while (rem > 0) begin
            int ch = PB - (a % PB);
            if (rem < ch) ch = rem;
            exp_bytes.push_back(8'h06); exp_lens.push_back(1);
            exp_bytes.push_back(8'h02);
            exp_bytes.push_back(a[23:16]); exp_bytes.push_back(a[15:8]); exp_bytes.push_back(a[7:0]);
            for (int j = 0; j < ch; j++) exp_bytes.push_back(src[exp_pops + j]);
            exp_lens.push_back(4 + ch);
            push_polls(busy);
            exp_pops += ch; a = (a + ch) & 24'hFFFFFF; rem -= ch;
            if (busy >= PM) break;
         end
      end else begin
         exp_bytes.push_back(8'h06); exp_lens.push_back(1);
         if (op == 4) begin
            exp_bytes.push_back(8'hC7); exp_lens.push_back(1);
         end else begin
            exp_bytes.push_back(op == 1 ? 8'h20 : op == 2 ? 8'h52 : 8'hD8);
            exp_bytes.push_back(addr[23:16]); exp_bytes.push_back(addr[15:8]);
            exp_bytes.push_back(addr[7:0]);
            exp_lens.push_back(4);
         end
         push_polls(busy);
      end
   endfunction

   task automatic run_req(int op, int addr, int len, int busy, int seed, bit poke);
      for (int i = 0; i < 1024; i++) src[i] = 8'((i * 37 + seed * 11 + (i >> 3)) & 255);
      @(negedge clk);
      pop_idx = 0;
      cfg_busy = busy;
      build(op, addr, len, busy);
      done_seen = 0;
      req_op = 3'(op); req_addr = 24'(addr); req_len_m1 = LW'(len - 1); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         repeat (300) @(negedge clk);
         req_op = 3'd1; req_addr = 24'h0ABCDE; req_valid = 1'b1;   // R1: ignored while busy
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(spi_cs_n && exp_lens.size() == 0, "R7 R1", "idle after completion", spi_cs_n, 1);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         mismatched++; compared++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R9", "reset port", {spi_cs_n, spi_sck}, 2);
      chk(done == 1'b0 && data_pop == 1'b0, "R8", "reset done", done, 0);
      run_req(0, 24'h001230, 4, 3, 1, 0);      // R3 R6 R8 single round
      run_req(0, 24'h0000F0, 40, 1, 2, 0);     // R5 split 16 + 24
      run_req(0, 24'h0102FE, 600, 0, 3, 1);    // R5 split 2+256+256+86, R1 poke
      run_req(0, 24'h000200, 256, 2, 4, 0);    // R5 exactly one page
      run_req(0, 24'h0000FF, 1, 0, 5, 0);      // R5 last byte of page
      run_req(1, 24'h045678, 1, 2, 6, 0);      // R4 sector
      run_req(2, 24'h0A8000, 1, 0, 7, 0);      // R4 half block
      run_req(3, 24'h3F0000, 1, 4, 8, 0);      // R4 block
      run_req(4, 24'h123456, 1, 5, 9, 0);      // R4 whole device, no address
      run_req(1, 24'h001000, 1, 50, 10, 0);    // R7 erase timeout
      run_req(0, 24'h0000FC, 10, 50, 11, 0);   // R7 program timeout drops rounds
      run_req(6, 24'h000000, 1, 0, 12, 0);     // R10 unknown operation
      run_req(0, 24'h00F0F0, 5, 1, 13, 0);     // R6 recovery after timeouts
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule